// File: doc/BRIEF.md
# Translation Address Range Checker

This block decides, before any page-table walk begins, whether a 64-bit address can be translated under the active paging mode. A request carries the address, the kind of access (instruction fetch, load or store), the translation stage, and the paging mode. The stage is either first-stage, where the address is a virtual address, or second-stage, where it is a widened guest physical address. One clock cycle later the block returns a pass or fault flag and, on a fault, the exception cause code the core should raise.

The two stages use different upper-bit rules. A first-stage address is legal when every bit above the translated width copies the top translated bit, so the address is a sign extension. A second-stage address gets two extra bits of width, and every bit above that window must be zero. An address that is a valid sign extension can therefore still fault when it is presented as a guest physical address.

The legal width is 12 page-offset bits plus 9 index bits for each table level, for 3, 4 or 5 levels. Second-stage modes add 2 to that width. The register that holds the result is the only state in the block.

Top module: `addr_range_chk`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released until the first request, res_valid, res_fault and res_cause are all zero.
- R2: res_valid is high exactly in the cycle after a cycle with in_valid high. In any cycle where res_valid is low, res_fault and res_cause are zero.
- R3: Mode code 0 (no translation) passes every address in both stages.
- R4: First stage (in_stage = 0) with mode code 2 (3 levels, 39-bit width) faults unless bits 63 to 39 all equal bit 38.
- R5: First stage with mode code 3 (4 levels) requires bits 63 to 48 to equal bit 47. Mode code 4 (5 levels) requires bits 63 to 57 to equal bit 56.
- R6: Second stage (in_stage = 1) with mode code 2 faults unless bits 63 to 41 are all zero. Bits 40 to 0 are free.
- R7: Second stage with mode code 3 requires bits 63 to 50 to be zero, and mode code 4 requires bits 63 to 59 to be zero. For example, 0xFFFF_FFFF_FF01_0000 faults in second stage with mode code 2, even though it passes in first stage with mode code 2.
- R8: Mode code 1 (32-bit paging) applies no upper-bit test and passes every address in both stages.
- R9: Access codes are 0 = fetch, 1 = load, 2 = store, and 3 is handled as a load. A first-stage fault reports cause 12, 13 or 15 for fetch, load or store. A second-stage fault reports 20, 21 or 23. A passing result reports cause 0.
- R10: Mode codes 5 to 7 always fault, with the cause from R9 for the request's stage and access code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Address to check |
| in_acc | input | 2 | Access code: 0 fetch, 1 load, 2 store, 3 load |
| in_stage | input | 1 | 0 = first stage (virtual), 1 = second stage (guest physical) |
| in_mode | input | 3 | Paging mode code 0 to 4; 5 to 7 are unsupported |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_fault | output | 1 | Address is out of range for the mode |
| res_cause | output | 5 | Exception cause on a fault, else 0 |

## Verification
Random addresses come from four shapes:
- a full 64-bit random value, which nearly always faults;
- a sign extension from a random bit;
- a zero extension from a random bit;
- a sign extension with one upper bit flipped.

Sign-extended shapes from above and below each width separate the first-stage rule from the second-stage one. Zero-extended shapes just over the second-stage window show whether the two extra bits are granted. Directed cases exercise:
- the bit-38, bit-40 and bit-41 boundaries;
- the all-ones guest address that must fault;
- every access code under the unsupported mode codes.

Idle cycles mixed between requests check that the result strobe and fields return to zero.

// File: rtl/addr_chk_pkg.sv
package addr_chk_pkg;

    localparam int CAUSE_W = 5;

    // Paging mode codes. Codes 5 to 7 are unsupported.
    typedef enum logic [2:0] {
        MODE_BARE = 3'd0,
        MODE_P32  = 3'd1,
        MODE_L3   = 3'd2,
        MODE_L4   = 3'd3,
        MODE_L5   = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam logic [CAUSE_W-1:0] CAUSE_PF_BASE  = 5'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_GPF_BASE = 5'd20;

    typedef struct packed {
        logic               valid;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } res_t;

endpackage

// File: rtl/addr_sext_chk.sv
// Passes when every bit of the slice (the top translated bit and all bits
// above it) holds the same value.
module addr_sext_chk #(
    parameter int HI_W = 26
) (
    input  logic [HI_W-1:0] hi_bits,
    output logic            ok
);
    always_comb begin
        ok = (&hi_bits) | ~(|hi_bits);
    end
endmodule

// File: rtl/addr_zext_chk.sv
// Passes when every bit above the widened guest window is zero.
module addr_zext_chk #(
    parameter int HI_W = 23
) (
    input  logic [HI_W-1:0] hi_bits,
    output logic            ok
);
    always_comb begin
        ok = ~(|hi_bits);
    end
endmodule

// File: rtl/addr_cause_enc.sv
module addr_cause_enc
    import addr_chk_pkg::*;
(
    input  logic               stage,
    input  logic [1:0]         acc,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] base;
    logic [CAUSE_W-1:0] offs;

    always_comb begin
        base = stage ? CAUSE_GPF_BASE : CAUSE_PF_BASE;
        unique case (acc)
            ACC_FETCH: offs = 5'd0;
            ACC_STORE: offs = 5'd3;
            default:   offs = 5'd1;  // load, and the reserved code as a load
        endcase
        cause = base + offs;
    end
endmodule

// File: rtl/addr_range_chk.sv
module addr_range_chk
    import addr_chk_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PG_OFF_W = 12,
    parameter int IDX_W    = 9,
    parameter int MIN_LVL  = 3,
    parameter int N_LVL    = 3,
    parameter int WIDEN_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [1:0]         in_acc,
    input  logic               in_stage,
    input  logic [2:0]         in_mode,
    output logic               res_valid,
    output logic               res_fault,
    output logic [CAUSE_W-1:0] res_cause
);

    localparam int SEL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1;

    logic [N_LVL-1:0]   sext_ok;
    logic [N_LVL-1:0]   zext_ok;
    logic [CAUSE_W-1:0] cause_w;
    res_t               res_d, res_q;

    // One pair of range checkers for each supported table depth.
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        localparam int VA_W  = PG_OFF_W + (MIN_LVL + g) * IDX_W;
        localparam int GPA_W = VA_W + WIDEN_W;

        addr_sext_chk #(.HI_W(ADDR_W - VA_W + 1)) u_sext (
            .hi_bits (in_addr[ADDR_W-1:VA_W-1]),
            .ok      (sext_ok[g])
        );

        addr_zext_chk #(.HI_W(ADDR_W - GPA_W)) u_zext (
            .hi_bits (in_addr[ADDR_W-1:GPA_W]),
            .ok      (zext_ok[g])
        );
    end

    addr_cause_enc u_cause (
        .stage (in_stage),
        .acc   (in_acc),
        .cause (cause_w)
    );

    logic             legal;
    logic [2:0]       lvl_code;
    logic [SEL_W-1:0] lvl_sel;

    always_comb begin
        // A mode code of L-1 selects a table depth of L levels.
        lvl_code = in_mode - 3'(MIN_LVL - 1);
        lvl_sel  = lvl_code[SEL_W-1:0];
        legal    = 1'b0;
        if (in_mode == MODE_BARE || in_mode == MODE_P32) begin
            legal = 1'b1;
        end else if (in_mode >= 3'(MIN_LVL - 1) && in_mode < 3'(MIN_LVL - 1 + N_LVL)) begin
            legal = in_stage ? zext_ok[lvl_sel] : sext_ok[lvl_sel];
        end

        res_d       = '0;
        res_d.valid = in_valid;
        if (in_valid && !legal) begin
            res_d.fault = 1'b1;
            res_d.cause = cause_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_fault = res_q.fault;
    assign res_cause = res_q.cause;

endmodule

// File: rtl/addr_range_chk_sva.sv
module addr_range_chk_sva
    import addr_chk_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_stage,
    input logic [2:0]         in_mode,
    input logic               res_valid,
    input logic               res_fault,
    input logic [CAUSE_W-1:0] res_cause
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);  // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);  // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_fault && res_cause == '0));  // R2
    AST_PASS_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> res_cause == '0);  // R9
    AST_BARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mode == 3'd0 || in_mode == 3'd1)) |=> !res_fault);  // R3 R8
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode > 3'd4) |=> res_fault);  // R10
    AST_GUEST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_stage) |=> (!res_fault || res_cause inside {5'd20, 5'd21, 5'd23}));  // R9
    AST_FIRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_stage) |=> (!res_fault || res_cause inside {5'd12, 5'd13, 5'd15}));  // R9
endmodule

bind addr_range_chk addr_range_chk_sva u_sva (.*);

// File: tb/tb_addr_range_chk.sv
module tb_addr_range_chk;
    localparam time CLK_P = 10ns;
    localparam int  WDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [1:0]  in_acc = '0;
    logic        in_stage = 1'b0;
    logic [2:0]  in_mode = '0;
    logic        res_valid;
    logic        res_fault;
    logic [4:0]  res_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit          p_valid = 0;
    bit          p_fault = 0;
    logic [4:0]  p_cause = '0;
    string       p_tag = "R2";

    always #(CLK_P/2) clk = ~clk;

    addr_range_chk dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_acc(in_acc), .in_stage(in_stage), .in_mode(in_mode),
        .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause)
    );

    function automatic bit exp_legal(logic [63:0] a, bit stg, logic [2:0] md);
        int w;
        if (md == 3'd0 || md == 3'd1) return 1;  // R3 R8
        if (md > 3'd4) return 0;                 // R10
        w = 12 + 9 * (int'(md) + 1);
        if (stg) begin
            w += 2;
            for (int i = w; i < 64; i++) if (a[i]) return 0;
        end else begin
            for (int i = w; i < 64; i++) if (a[i] != a[w-1]) return 0;
        end
        return 1;
    endfunction

    function automatic logic [4:0] exp_cause(bit stg, logic [1:0] ac);
        int b = stg ? 20 : 12;
        if (ac == 2'd0) return 5'(b);
        if (ac == 2'd2) return 5'(b + 3);
        return 5'(b + 1);
    endfunction

    function automatic string tag_of(bit stg, logic [2:0] md);
        if (md == 3'd0) return "R3";
        if (md == 3'd1) return "R8";
        if (md > 3'd4)  return "R10";
        if (md == 3'd2) return stg ? "R6" : "R4";
        return stg ? "R7" : "R5";
    endfunction

    task automatic check(string tag, bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: compare the result of the previous request, then drive the next.
    task automatic step(bit v, logic [63:0] a, logic [1:0] ac, bit stg, logic [2:0] md);
        bit f;
        @(negedge clk);
        check(p_valid ? p_tag : "R2", res_valid == p_valid, "valid", 64'(res_valid), 64'(p_valid));
        check(p_valid ? p_tag : "R2", res_fault == p_fault, "fault", 64'(res_fault), 64'(p_fault));
        check(p_fault ? "R9" : "R2", res_cause == p_cause, "cause", 64'(res_cause), 64'(p_cause));
        in_valid = v; in_addr = a; in_acc = ac; in_stage = stg; in_mode = md;
        f = v && !exp_legal(a, stg, md);
        p_valid = v;
        p_fault = f;
        p_cause = f ? exp_cause(stg, ac) : 5'd0;
        p_tag   = tag_of(stg, md);
    endtask

    function automatic logic [63:0] gen_addr();
        logic [63:0] a = {$urandom(), $urandom()};
        int k = int'($urandom() % 4);
        int b = 30 + int'($urandom() % 33);
        if (k == 1 || k == 3) for (int i = b + 1; i < 64; i++) a[i] = a[b];
        if (k == 2) for (int i = b + 1; i < 64; i++) a[i] = 1'b0;
        if (k == 3) a[b + 1 + int'($urandom() % (63 - b))] ^= 1'b1;
        return a;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", res_valid == 0 && res_fault == 0 && res_cause == 0, "reset outputs",
              {58'd0, res_valid, res_fault, res_cause}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", res_valid == 0 && res_fault == 0 && res_cause == 0, "after reset",
              {58'd0, res_valid, res_fault, res_cause}, 64'd0);

        // Directed corner cases
        step(1, 64'hFFFF_FFFF_FF01_0000, 2'd1, 1, 3'd2);  // R7: sign-extended guest address faults
        step(1, 64'hFFFF_FFFF_FF01_0000, 2'd1, 0, 3'd2);  // R4: passes in first stage
        step(1, 64'h0000_0040_0000_0000, 2'd0, 0, 3'd2);  // R4: bit 38 set alone faults
        step(1, 64'h0000_0040_0000_0000, 2'd2, 1, 3'd2);  // R6: bit 38 is inside the guest window
        step(1, 64'h0000_0100_0000_0000, 2'd0, 1, 3'd2);  // R6: bit 40 passes
        step(1, 64'h0000_0200_0000_0000, 2'd2, 1, 3'd2);  // R6: bit 41 faults
        step(0, '0, 2'd0, 0, 3'd0);                        // R2: idle
        step(1, 64'h0004_0000_0000_0000, 2'd0, 1, 3'd3);  // R7: bit 50 faults
        step(1, 64'h0800_0000_0000_0000, 2'd0, 1, 3'd4);  // R7: bit 59 faults
        step(1, 64'h0400_0000_0000_0000, 2'd0, 1, 3'd4);  // R7: bit 58 passes
        step(1, 64'hFFFF_8000_0000_0000, 2'd1, 0, 3'd3);  // R5: valid 48-bit sign extension
        step(1, 64'hFF00_0000_0000_0000, 2'd1, 0, 3'd4);  // R5: valid 57-bit sign extension
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1, 3'd0);  // R3
        step(1, 64'hDEAD_BEEF_0000_0000, 2'd2, 0, 3'd1);  // R8
        for (int ac = 0; ac < 4; ac++)
            for (int s = 0; s < 2; s++)
                step(1, '0, 2'(ac), s[0], 3'd5 + 3'(ac % 3));  // R10 R9
        step(0, '0, 2'd0, 0, 3'd0);

        // Random traffic
        for (int n = 0; n < 3000; n++)
            step(($urandom() % 5) != 0, gen_addr(), 2'($urandom()), 1'($urandom()), 3'($urandom()));
        step(0, '0, 2'd0, 0, 3'd0);
        step(0, '0, 2'd0, 0, 3'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule